// File: doc/BRIEF.md
# Stale Victim Filter

This block sits in front of a directory controller and decides, for each incoming victim (eviction) request, whether the writeback it carries is still wanted. A probe can collect a core's data while that core's victim request is still in flight. When that happens, the core sends a stale notice that names the line. The filter records this as one ignore bit per core for that line. When the victim request from that core later arrives, it is turned into a drop event instead of a writeback, so it cannot overwrite newer data.

Ignore vectors live in a small table indexed by the low bits of the line address. A stale notice sets the sender's bit. A victim request, dirty or clean, reads its requester's bit. If the bit is set, the request is reported as a drop and that one bit is cleared. If the bit is clear, the request passes on as an ordinary dirty or clean victim event. The directory then handles it as usual: it locks the line when the line is unblocked, or holds the request while the line is busy. Directory storage, the writeback path and the acknowledgement traffic belong to other blocks.

Top module: `stale_victim_filter`

## Requirements
- R1: After reset, every ignore bit is zero, so every victim request passes, and evtValid is low with evtKind equal to 2'b00.
- R2: A stale notice (notifValid high) sets the ignore bit of core notifCore for table row notifAddr[IDX_W-1:0].
- R3: Dirty and clean victim requests are both checked against the requester's ignore bit. If that bit is set, the event is a drop, evtKind = 2'b11.
- R4: A victim request whose requester bit is clear is reported unchanged: evtKind = 2'b01 when vicDirty is 1 and 2'b10 when vicDirty is 0, with evtAddr and evtCore equal to vicAddr and vicCore.
- R5: A drop clears only the requester's bit in that row. The bits of the other cores in that row stay set or clear as they were.
- R6: If a notice sets a bit in the same cycle that a drop would clear it, the bit ends up set. The victim in that cycle is still classified by the bit value before that cycle.
- R7: Each victim request produces exactly one event, registered, one clock after the request is sampled. evtValid is low in every other cycle.
- R8: Rows are selected by vicAddr/notifAddr bits [IDX_W-1:0]. A notice for one row does not affect victim requests for a different row.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| vicValid | input | 1 | Victim request present |
| vicAddr | input | ADDR_W | Line address of the victim |
| vicCore | input | CORE_W | Requesting core |
| vicDirty | input | 1 | 1 for a dirty victim, 0 for a clean one |
| notifValid | input | 1 | Stale notice present |
| notifAddr | input | ADDR_W | Line address named by the notice |
| notifCore | input | CORE_W | Core that sent the notice |
| evtValid | output | 1 | Classified event valid |
| evtKind | output | 2 | 01 dirty victim, 10 clean victim, 11 drop, 00 none |
| evtAddr | output | ADDR_W | Address of the classified victim |
| evtCore | output | CORE_W | Requester of the classified victim |

## Verification
The bench marks two cores on one line and then drops one of them. A filter that clears the whole row instead of one bit would then let the second core's victim through as a writeback. It repeats a victim after a drop, which catches a bit that is never cleared, because every later writeback from that core would be lost. It issues a notice and a matching victim in the same cycle, which catches a clear that wins over a set, because the next stale victim would then slip through. It also checks a clean victim, a neighbouring row, and a reset in the middle of a run, which expose a dirty-only check, row aliasing and ignore state that survives reset.

// File: rtl/svf_pkg.sv
package svf_pkg;
  typedef enum logic [1:0] {
    EVT_NONE      = 2'b00,
    EVT_VIC_DIRTY = 2'b01,
    EVT_VIC_CLEAN = 2'b10,
    EVT_DROP      = 2'b11
  } evt_kind_e;
endpackage

// File: rtl/svf_store.sv
module svf_store #(
  parameter int NUM_CORES = 4,
  parameter int IDX_W     = 3,
  parameter int CORE_W    = 2,
  parameter type strobe_t = logic
) (
  input  logic              clk,
  input  logic              rst_n,
  input  strobe_t           strobes,
  input  logic [IDX_W-1:0]  rdIdx,
  input  logic [CORE_W-1:0] rdCore,
  output logic              rdBit
);
  localparam int DEPTH = 1 << IDX_W;

  logic [NUM_CORES-1:0] ignoreTbl [DEPTH];
  logic [NUM_CORES-1:0] clrMask;

  assign clrMask = NUM_CORES'(1) << strobes.clrCore;
  assign rdBit   = ignoreTbl[rdIdx][rdCore];

  for (genvar r = 0; r < DEPTH; r++) begin : g_row
    logic [NUM_CORES-1:0] rowNext;
    always_comb begin
      rowNext = ignoreTbl[r];
      if (strobes.clrEn && strobes.clrIdx == IDX_W'(r))
        rowNext[strobes.clrCore] = 1'b0;
      if (strobes.setEn && strobes.setIdx == IDX_W'(r))
        rowNext[strobes.setCore] = 1'b1;
    end
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) ignoreTbl[r] <= '0;
      else        ignoreTbl[r] <= rowNext;
    end
  end

  AST_SET_STICKS: assert property (@(posedge clk) disable iff (!rst_n)
    strobes.setEn |=> ignoreTbl[$past(strobes.setIdx)][$past(strobes.setCore)]); // R6

  AST_CLEAR_TAKES: assert property (@(posedge clk) disable iff (!rst_n)
    strobes.clrEn && !(strobes.setEn && strobes.setIdx == strobes.clrIdx
                       && strobes.setCore == strobes.clrCore)
    |=> !ignoreTbl[$past(strobes.clrIdx)][$past(strobes.clrCore)]); // R5

  AST_ROW_OTHERS_KEPT: assert property (@(posedge clk) disable iff (!rst_n)
    strobes.clrEn && !strobes.setEn
    |=> ((ignoreTbl[$past(strobes.clrIdx)] | $past(clrMask))
         == $past(ignoreTbl[strobes.clrIdx] | clrMask))); // R5
endmodule

// File: rtl/svf_ctrl.sv
module svf_ctrl
  import svf_pkg::*;
#(
  parameter int ADDR_W    = 16,
  parameter int IDX_W     = 3,
  parameter int CORE_W    = 2,
  parameter type strobe_t = logic
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              vicValid,
  input  logic [ADDR_W-1:0] vicAddr,
  input  logic [CORE_W-1:0] vicCore,
  input  logic              vicDirty,
  input  logic              notifValid,
  input  logic [ADDR_W-1:0] notifAddr,
  input  logic [CORE_W-1:0] notifCore,
  input  logic              rdBit,
  output logic [IDX_W-1:0]  rdIdx,
  output logic [CORE_W-1:0] rdCore,
  output strobe_t           strobes,
  output logic              evtValid,
  output logic [1:0]        evtKind,
  output logic [ADDR_W-1:0] evtAddr,
  output logic [CORE_W-1:0] evtCore
);
  evt_kind_e kindNext;

  assign rdIdx  = vicAddr[IDX_W-1:0];
  assign rdCore = vicCore;

  always_comb begin
    strobes         = '0;
    strobes.setEn   = notifValid;
    strobes.setIdx  = notifAddr[IDX_W-1:0];
    strobes.setCore = notifCore;
    strobes.clrEn   = vicValid && rdBit;
    strobes.clrIdx  = vicAddr[IDX_W-1:0];
    strobes.clrCore = vicCore;
  end

  always_comb begin
    if (!vicValid)    kindNext = EVT_NONE;
    else if (rdBit)   kindNext = EVT_DROP;
    else if (vicDirty) kindNext = EVT_VIC_DIRTY;
    else              kindNext = EVT_VIC_CLEAN;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      evtValid <= 1'b0;
      evtKind  <= EVT_NONE;
      evtAddr  <= '0;
      evtCore  <= '0;
    end else begin
      evtValid <= vicValid;
      evtKind  <= kindNext;
      evtAddr  <= vicValid ? vicAddr : '0;
      evtCore  <= vicValid ? vicCore : '0;
    end
  end

  AST_ONE_EVENT_PER_VICTIM: assert property (@(posedge clk) disable iff (!rst_n)
    vicValid |=> evtValid); // R7
  AST_NO_SPURIOUS_EVENT: assert property (@(posedge clk) disable iff (!rst_n)
    !vicValid |=> !evtValid); // R7
  AST_MARKED_DROPS: assert property (@(posedge clk) disable iff (!rst_n)
    vicValid && rdBit |=> evtKind == EVT_DROP); // R3
  AST_UNMARKED_PASSES: assert property (@(posedge clk) disable iff (!rst_n)
    vicValid && !rdBit |=> evtKind != EVT_DROP && evtAddr == $past(vicAddr)); // R4
  AST_KIND_LEGAL: assert property (@(posedge clk) disable iff (!rst_n)
    evtValid |-> evtKind != EVT_NONE); // R7
endmodule

// File: rtl/stale_victim_filter.sv
module stale_victim_filter #(
  parameter int ADDR_W    = 16,
  parameter int NUM_CORES = 4,
  parameter int IDX_W     = 3,
  localparam int CORE_W   = (NUM_CORES > 1) ? $clog2(NUM_CORES) : 1
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              vicValid,
  input  logic [ADDR_W-1:0] vicAddr,
  input  logic [CORE_W-1:0] vicCore,
  input  logic              vicDirty,
  input  logic              notifValid,
  input  logic [ADDR_W-1:0] notifAddr,
  input  logic [CORE_W-1:0] notifCore,
  output logic              evtValid,
  output logic [1:0]        evtKind,
  output logic [ADDR_W-1:0] evtAddr,
  output logic [CORE_W-1:0] evtCore
);
  typedef struct packed {
    logic              setEn;
    logic [IDX_W-1:0]  setIdx;
    logic [CORE_W-1:0] setCore;
    logic              clrEn;
    logic [IDX_W-1:0]  clrIdx;
    logic [CORE_W-1:0] clrCore;
  } strobe_t;

  strobe_t           strobes;
  logic [IDX_W-1:0]  rdIdx;
  logic [CORE_W-1:0] rdCore;
  logic              rdBit;

  svf_ctrl #(.ADDR_W(ADDR_W), .IDX_W(IDX_W), .CORE_W(CORE_W), .strobe_t(strobe_t)) i_ctrl (
    .clk(clk), .rst_n(rst_n),
    .vicValid(vicValid), .vicAddr(vicAddr), .vicCore(vicCore), .vicDirty(vicDirty),
    .notifValid(notifValid), .notifAddr(notifAddr), .notifCore(notifCore),
    .rdBit(rdBit), .rdIdx(rdIdx), .rdCore(rdCore), .strobes(strobes),
    .evtValid(evtValid), .evtKind(evtKind), .evtAddr(evtAddr), .evtCore(evtCore)
  );

  svf_store #(.NUM_CORES(NUM_CORES), .IDX_W(IDX_W), .CORE_W(CORE_W), .strobe_t(strobe_t)) i_store (
    .clk(clk), .rst_n(rst_n), .strobes(strobes),
    .rdIdx(rdIdx), .rdCore(rdCore), .rdBit(rdBit)
  );
endmodule

// File: tb/test_stale_victim_filter.sv
module test_stale_victim_filter;
  localparam int ADDR_W = 16;
  localparam int CORE_W = 2;

  typedef struct packed {
    logic       vV;
    logic [3:0] vA;
    logic [1:0] vC;
    logic       vD;
    logic       nV;
    logic [3:0] nA;
    logic [1:0] nC;
    logic       eV;
    logic [1:0] eK;
  } vec_t;

  localparam int NV = 15;
  localparam vec_t VECS [NV] = '{
    '{1'b1, 4'd1, 2'd0, 1'b1, 1'b0, 4'd0, 2'd0, 1'b1, 2'b01}, // R4 dirty pass
    '{1'b0, 4'd0, 2'd0, 1'b0, 1'b1, 4'd1, 2'd2, 1'b0, 2'b00}, // R2 mark line1 core2
    '{1'b1, 4'd1, 2'd2, 1'b0, 1'b0, 4'd0, 2'd0, 1'b1, 2'b11}, // R3 clean dropped
    '{1'b1, 4'd1, 2'd2, 1'b1, 1'b0, 4'd0, 2'd0, 1'b1, 2'b01}, // R5 cleared
    '{1'b0, 4'd0, 2'd0, 1'b0, 1'b1, 4'd2, 2'd1, 1'b0, 2'b00}, // R2 mark line2 core1
    '{1'b0, 4'd0, 2'd0, 1'b0, 1'b1, 4'd2, 2'd3, 1'b0, 2'b00}, // R2 mark line2 core3
    '{1'b1, 4'd2, 2'd1, 1'b1, 1'b0, 4'd0, 2'd0, 1'b1, 2'b11}, // R3 dirty dropped
    '{1'b1, 4'd2, 2'd3, 1'b0, 1'b0, 4'd0, 2'd0, 1'b1, 2'b11}, // R5 other bit kept
    '{1'b1, 4'd2, 2'd0, 1'b0, 1'b0, 4'd0, 2'd0, 1'b1, 2'b10}, // R4 clean pass
    '{1'b1, 4'd3, 2'd1, 1'b1, 1'b0, 4'd0, 2'd0, 1'b1, 2'b01}, // R8 neighbour row
    '{1'b0, 4'd0, 2'd0, 1'b0, 1'b1, 4'd6, 2'd2, 1'b0, 2'b00}, // R2 mark line6 core2
    '{1'b1, 4'd6, 2'd2, 1'b1, 1'b1, 4'd6, 2'd2, 1'b1, 2'b11}, // R6 set+clear
    '{1'b1, 4'd6, 2'd2, 1'b1, 1'b0, 4'd0, 2'd0, 1'b1, 2'b11}, // R6 set won
    '{1'b1, 4'd6, 2'd2, 1'b1, 1'b0, 4'd0, 2'd0, 1'b1, 2'b01}, // R5 now clear
    '{1'b0, 4'd0, 2'd0, 1'b0, 1'b0, 4'd0, 2'd0, 1'b0, 2'b00}  // R7 idle
  };

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic vicValid = 1'b0, vicDirty = 1'b0, notifValid = 1'b0;
  logic [ADDR_W-1:0] vicAddr = '0, notifAddr = '0;
  logic [CORE_W-1:0] vicCore = '0, notifCore = '0;
  logic evtValid;
  logic [1:0] evtKind;
  logic [ADDR_W-1:0] evtAddr;
  logic [CORE_W-1:0] evtCore;
  int errors = 0;
  int checks = 0;
  bit done = 1'b0;

  always #5 clk = ~clk;

  stale_victim_filter i_stale_victim_filter (
    .clk(clk), .rst_n(rst_n),
    .vicValid(vicValid), .vicAddr(vicAddr), .vicCore(vicCore), .vicDirty(vicDirty),
    .notifValid(notifValid), .notifAddr(notifAddr), .notifCore(notifCore),
    .evtValid(evtValid), .evtKind(evtKind), .evtAddr(evtAddr), .evtCore(evtCore)
  );

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic drive(input vec_t v);
    vicValid = v.vV; vicAddr = ADDR_W'(v.vA); vicCore = v.vC; vicDirty = v.vD;
    notifValid = v.nV; notifAddr = ADDR_W'(v.nA); notifCore = v.nC;
  endtask

  initial begin
    repeat (2) @(negedge clk);
    check("R1 evtValid after reset", 32'(evtValid), 0);
    check("R1 evtKind after reset", 32'(evtKind), 0);
    rst_n = 1'b1;
    @(negedge clk);
    for (int i = 0; i < NV; i++) begin
      drive(VECS[i]);
      @(negedge clk);
      check($sformatf("R7 vec%0d valid", i), 32'(evtValid), 32'(VECS[i].eV));
      check($sformatf("R3/R4 vec%0d kind", i), 32'(evtKind), 32'(VECS[i].eK));
      if (VECS[i].vV) begin
        check($sformatf("R4 vec%0d addr", i), 32'(evtAddr), 32'(VECS[i].vA));
        check($sformatf("R4 vec%0d core", i), 32'(evtCore), 32'(VECS[i].vC));
      end
    end
    // R1: reset in mid-run clears a marked bit
    drive('{1'b0, 4'd0, 2'd0, 1'b0, 1'b1, 4'd7, 2'd1, 1'b0, 2'b00});
    @(negedge clk);
    drive('0);
    rst_n = 1'b0;
    @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    drive('{1'b1, 4'd7, 2'd1, 1'b0, 1'b0, 4'd0, 2'd0, 1'b1, 2'b10});
    @(negedge clk);
    check("R1 bit cleared by reset", 32'(evtKind), 32'(2'b10));
    drive('0);
    @(negedge clk);
    check("R7 idle after victim", 32'(evtValid), 0);
    done = 1'b1;
  end

  initial begin
    for (int c = 0; c < 2000 && !done; c++) @(posedge clk);
    if (!done) begin
      checks++;
      errors++;
      $display("FAIL watchdog: actual=hung expected=done");
    end
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule